// File: doc/BRIEF.md
# Sector Buffer DMA Fill/Empty Sequencer

This block moves a run of 16-bit words between host memory and a local sector buffer for the two host-side buffer commands. Software writes a command word with a start bit into the control register. The block then raises a transfer-request flag twice through the data register. The first write after the flag is the word count. The second write is the low 16 bits of the bus address. Two extra control bits supply the top two bits of an 18-bit address.

Once both parameters are loaded, the sequencer walks memory one word at a time through a request/acknowledge port. It counts the word count down and steps the address by two bytes per word. A fill loads the buffer from index 0 and then writes zeros over every buffer word up to the density limit. An empty copies buffer words out to memory and does not change the buffer, so it can be repeated.

A word count above the limit, or a memory cycle with no acknowledge, ends the command with an error. On every completion the error/status word is placed in the data register. An interrupt request is raised while the command is complete and interrupts are enabled.

Top module: `sbuf_dma_seq`

## Requirements
- R1: A control write with bit 0 (start) set and function bits 3:1 equal to 000 (fill) or 001 (empty) starts a command only while DONE (bit 5) is 1. Starting clears DONE and ERROR (bit 15) and sets TR (bit 7). A start with any other function code leaves DONE=1 and TR=0.
- R2: While TR is 1, the first data-register write loads the word count and clears TR. TR reads 1 again on the following cycle, and the next write loads the address bits 15:0, after which TR stays 0. Data-register writes while TR is 0 leave the data register readback unchanged.
- R3: A fill reads exactly word-count words from host memory (mem_we=0). It stores them at buffer indices 0, 1, 2, ... in that order.
- R4: The buffer limit is 64 words when bit 8 is 0 and 128 words when bit 8 is 1. After a fill, every buffer word from index word-count up to the limit minus 1 reads as zero. A word count of 0 gives an all-zero buffer.
- R5: An empty writes word-count buffer words to host memory (mem_we=1), starting at index 0, and leaves the buffer contents unchanged. Two consecutive empties therefore write identical data.
- R6: A word count greater than the limit issues no memory request. It ends with DONE=1, ERROR=1 and status bit 10 set.
- R7: When mem_req stays high for 64 consecutive cycles without mem_ack, the command ends with DONE=1, ERROR=1 and status bit 11 set. An acknowledge arriving in the 64th cycle completes that word normally.
- R8: On every completion the data register reads the status word: bit 10 for count overflow, bit 11 for no response, and all other bits 0. ERROR equals the OR of those two bits.
- R9: irq is 1 exactly when DONE and the interrupt-enable bit 6 are both 1.
- R10: The word address on mem_addr is {bits 13:12, address word} for the first word and increases by 2 for each later word. A carry out of bit 15 propagates into bits 17:16.
- R11: A control write while a command is in progress updates only the interrupt enable bit. Function, density and the extended address bits keep their values, and the start bit is ignored.
- R12: After reset the control register reads 0x0020, the data register reads 0, and irq and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 16 | Control register write data |
| csr_q | output | 16 | Control register readback |
| dr_we | input | 1 | Data register write strobe |
| dr_wdata | input | 16 | Data register write data |
| dr_q | output | 16 | Data register readback (status word after completion) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle direction, 1 = write to host memory |
| mem_addr | output | 18 | Byte address of the current word |
| mem_wdata | output | 16 | Word written to host memory |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Word read from host memory, valid with mem_ack |

## Verification
The acknowledge and the no-response timeout can land in the same cycle. This happens when the acknowledge is delayed until the 64th cycle of a request. The bench's memory responder holds its acknowledge for a programmable number of request cycles. It runs once with 63 idle cycles, where the transfer must finish cleanly with every word read, and once with 64, where it must abort with status bit 11 and no word accepted. A second coincidence is the last data word of a fill also deciding whether padding follows. This is judged by sweeping word counts of 0, 1, limit-1 and limit in both densities and reading the whole buffer back through empty commands.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    // Control register bit positions
    localparam int CSR_GO   = 0;
    localparam int CSR_DONE = 5;
    localparam int CSR_IE   = 6;
    localparam int CSR_TR   = 7;
    localparam int CSR_DEN  = 8;
    localparam int CSR_XLO  = 12;
    localparam int CSR_ERR  = 15;

    // Status word bit positions
    localparam int STS_WCOVF = 10;
    localparam int STS_NXM   = 11;

    // Function codes
    localparam logic [2:0] FN_FILL  = 3'b000;
    localparam logic [2:0] FN_EMPTY = 3'b001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WC,
        ST_GAP,
        ST_BA,
        ST_CHK,
        ST_XFER,
        ST_PAD
    } seq_st_e;

    typedef struct packed {
        logic ovf;
        logic nxm;
    } fault_t;

    function automatic logic [15:0] status_word(fault_t f);
        logic [15:0] s;
        s = '0;
        s[STS_WCOVF] = f.ovf;
        s[STS_NXM]   = f.nxm;
        return s;
    endfunction

    function automatic logic fn_known(logic [2:0] fn);
        return (fn == FN_FILL) || (fn == FN_EMPTY);
    endfunction

endpackage

// File: rtl/sbuf_ram.sv
module sbuf_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/sbuf_bus_port.sv
module sbuf_bus_port #(
    parameter int AW  = 18,
    parameter int DW  = 16,
    parameter int TMO = 64,
    localparam int TW = $clog2(TMO + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          hit,
    output logic          tmo
);
    logic [TW-1:0] wait_cnt;

    assign mem_req   = active;
    assign mem_we    = active & wr;
    assign mem_addr  = addr;
    assign mem_wdata = wdata;
    assign hit       = active & mem_ack;
    assign tmo       = active & ~mem_ack & (wait_cnt == TW'(TMO - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || mem_ack || tmo) wait_cnt <= '0;
        else                                  wait_cnt <= wait_cnt + TW'(1);
    end
endmodule

// File: rtl/sbuf_dma_seq.sv
module sbuf_dma_seq
    import sbuf_pkg::*;
#(
    parameter int WORDS_SD = 64,
    parameter int WORDS_DD = 128,
    parameter int TMO_CYC  = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_we,
    input  logic [15:0] csr_wdata,
    output logic [15:0] csr_q,
    input  logic        dr_we,
    input  logic [15:0] dr_wdata,
    output logic [15:0] dr_q,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [17:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata
);
    localparam int DEPTH = (WORDS_DD > WORDS_SD) ? WORDS_DD : WORDS_SD;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = IW + 1;
    localparam logic [CW-1:0] LIM_SD = CW'(WORDS_SD);
    localparam logic [CW-1:0] LIM_DD = CW'(WORDS_DD);

    seq_st_e       st;
    logic          done_q, tr_q, err_q, ie_q, dens_q;
    logic [2:0]    fn_q;
    logic [1:0]    ext_q;
    logic [15:0]   wc_q;
    logic [17:0]   addr_q;
    logic [IW-1:0] idx_q;
    logic [15:0]   dr_r;

    logic [CW-1:0] limit, nxt_cnt;
    logic          is_fill, over, go_pad, fin;
    fault_t        flt;
    logic          ram_we;
    logic [15:0]   ram_wd, ram_rd;
    logic          bus_ack, bus_tmo;
    logic          unused_bits;

    assign unused_bits = ^{csr_wdata[15:14], csr_wdata[11:9], csr_wdata[4]};

    assign limit   = dens_q ? LIM_DD : LIM_SD;
    assign nxt_cnt = {1'b0, idx_q} + CW'(1);
    assign is_fill = (fn_q == FN_FILL);
    assign over    = (wc_q > {{(16 - CW){1'b0}}, limit});
    assign go_pad  = is_fill && (nxt_cnt < limit);

    // Completion decode
    always_comb begin
        fin = 1'b0;
        flt = '0;
        unique case (st)
            ST_CHK: begin
                if (over) begin
                    fin     = 1'b1;
                    flt.ovf = 1'b1;
                end else if (wc_q == 16'd0 && !is_fill) begin
                    fin = 1'b1;
                end
            end
            ST_XFER: begin
                if (bus_tmo) begin
                    fin     = 1'b1;
                    flt.nxm = 1'b1;
                end else if (bus_ack && wc_q == 16'd1 && !go_pad) begin
                    fin = 1'b1;
                end
            end
            ST_PAD: fin = (nxt_cnt == limit);
            default: fin = 1'b0;
        endcase
    end

    assign ram_we = (st == ST_XFER && is_fill && bus_ack) || (st == ST_PAD);
    assign ram_wd = (st == ST_PAD) ? 16'd0 : mem_rdata;

    sbuf_ram #(.DEPTH(DEPTH), .DW(16)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (idx_q),
        .wdata (ram_wd),
        .raddr (idx_q),
        .rdata (ram_rd)
    );

    sbuf_bus_port #(.AW(18), .DW(16), .TMO(TMO_CYC)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .active    (st == ST_XFER),
        .wr        (!is_fill),
        .addr      (addr_q),
        .wdata     (ram_rd),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .hit       (bus_ack),
        .tmo       (bus_tmo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            tr_q   <= 1'b0;
            err_q  <= 1'b0;
            ie_q   <= 1'b0;
            dens_q <= 1'b0;
            fn_q   <= FN_FILL;
            ext_q  <= 2'd0;
            wc_q   <= 16'd0;
            addr_q <= 18'd0;
            idx_q  <= '0;
            dr_r   <= 16'd0;
        end else begin
            if (csr_we) ie_q <= csr_wdata[CSR_IE];

            if (fin) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= flt.ovf | flt.nxm;
                dr_r   <= status_word(flt);
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (csr_we) begin
                            fn_q   <= csr_wdata[3:1];
                            dens_q <= csr_wdata[CSR_DEN];
                            ext_q  <= csr_wdata[CSR_XLO +: 2];
                            if (csr_wdata[CSR_GO] && fn_known(csr_wdata[3:1])) begin
                                done_q <= 1'b0;
                                err_q  <= 1'b0;
                                tr_q   <= 1'b1;
                                st     <= ST_WC;
                            end
                        end
                    end
                    ST_WC: begin
                        if (dr_we) begin
                            wc_q <= dr_wdata;
                            tr_q <= 1'b0;
                            st   <= ST_GAP;
                        end
                    end
                    ST_GAP: begin
                        tr_q <= 1'b1;
                        st   <= ST_BA;
                    end
                    ST_BA: begin
                        if (dr_we) begin
                            addr_q <= {ext_q, dr_wdata};
                            tr_q   <= 1'b0;
                            idx_q  <= '0;
                            st     <= ST_CHK;
                        end
                    end
                    ST_CHK: begin
                        st <= (wc_q == 16'd0) ? ST_PAD : ST_XFER;
                    end
                    ST_XFER: begin
                        if (bus_ack) begin
                            wc_q   <= wc_q - 16'd1;
                            addr_q <= addr_q + 18'd2;
                            idx_q  <= idx_q + IW'(1);
                            if (wc_q == 16'd1) st <= ST_PAD;
                        end
                    end
                    ST_PAD: begin
                        idx_q <= idx_q + IW'(1);
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign csr_q = {err_q, 1'b0, ext_q, 3'b000, dens_q, tr_q, ie_q, done_q,
                    1'b0, fn_q, 1'b0};
    assign dr_q  = dr_r;
    assign irq   = done_q & ie_q;

endmodule

// File: rtl/sbuf_dma_seq_chk.sv
module sbuf_dma_seq_chk #(
    parameter int TMO_CYC = 64,
    localparam int TW     = $clog2(TMO_CYC + 1)
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] csr_q,
    input logic [15:0] dr_q,
    input logic        irq,
    input logic        mem_req,
    input logic [17:0] mem_addr,
    input logic        mem_ack
);
    logic [TW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || !mem_req || mem_ack) idle_cnt <= '0;
        else                            idle_cnt <= idle_cnt + TW'(1);
    end

    // R1: a start clears DONE while raising TR with ERROR clear
    a_r1_start_tr: assert property (@(posedge clk) disable iff (rst)
        $fell(csr_q[5]) |-> (csr_q[7] && !csr_q[15]));

    // R2: TR never shows while the block is idle
    a_r2_tr_busy: assert property (@(posedge clk) disable iff (rst)
        csr_q[7] |-> !csr_q[5]);

    // R3: memory cycles only after both parameters are loaded
    a_r3_req_phase: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (!csr_q[5] && !csr_q[7]));

    // R10: consecutive word addresses step by two bytes
    a_r10_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + 18'd2));

    // R7: no request waits beyond the timeout window
    a_r7_tmo_bound: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (idle_cnt < TW'(TMO_CYC)));

    // R7: final unanswered cycle aborts with the no-response status
    a_r7_tmo_abort: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && idle_cnt == TW'(TMO_CYC - 1))
        |=> (!mem_req && csr_q[5] && csr_q[15] && dr_q[11]));

    // R8: at completion ERROR mirrors the status word fault bits
    a_r8_status: assert property (@(posedge clk) disable iff (rst)
        $rose(csr_q[5]) |-> (csr_q[15] == (dr_q[10] | dr_q[11])));

    // R9: interrupt only when complete
    a_r9_irq_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> csr_q[5]);
endmodule

bind sbuf_dma_seq sbuf_dma_seq_chk #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .csr_q    (csr_q),
    .dr_q     (dr_q),
    .irq      (irq),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/sbuf_dma_seq_tb.sv
module sbuf_dma_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        csr_we, dr_we;
    logic [15:0] csr_wdata, dr_wdata, csr_q, dr_q;
    logic        irq, mem_req, mem_we, mem_ack;
    logic [17:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    sbuf_dma_seq u_dut (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_q(csr_q),
        .dr_we(dr_we), .dr_wdata(dr_wdata), .dr_q(dr_q),
        .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] hmem [0:511];
    int lat = 0;
    logic [17:0] exp_addr;
    int ack_cnt = 0;
    int addr_bad = 0;

    // Host memory responder: acknowledges after lat idle request cycles
    initial begin
        int wcnt;
        wcnt = 0;
        mem_ack = 1'b0;
        mem_rdata = 16'd0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req === 1'b1) begin
                if (wcnt == lat) begin
                    mem_ack = 1'b1;
                    if (mem_addr !== exp_addr) addr_bad++;
                    exp_addr = exp_addr + 18'd2;
                    ack_cnt++;
                    if (mem_we) hmem[mem_addr[9:1]] = mem_wdata;
                    else        mem_rdata = hmem[mem_addr[9:1]];
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_csr(input logic [15:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic wr_dr(input logic [15:0] v);
        @(negedge clk);
        dr_we = 1'b1; dr_wdata = v;
        @(negedge clk);
        dr_we = 1'b0;
    endtask

    task automatic wait_tr();
        for (int n = 0; n < 5000 && csr_q[7] !== 1'b1; n++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int n = 0; n < 20000 && csr_q[5] !== 1'b1; n++) @(negedge clk);
    endtask

    function automatic logic [15:0] cmd(input logic [2:0] fn, input logic dens,
                                        input logic [1:0] ext, input logic ie);
        return {2'b00, ext, 3'b000, dens, 1'b0, ie, 1'b0, 1'b0, fn, 1'b1};
    endfunction

    task automatic run(input logic [2:0] fn, input logic dens, input logic [1:0] ext,
                       input logic ie, input logic [15:0] wc, input logic [15:0] ba);
        exp_addr = {ext, ba};
        ack_cnt = 0;
        addr_bad = 0;
        wr_csr(cmd(fn, dens, ext, ie));
        wait_tr();
        wr_dr(wc);
        wait_tr();
        wr_dr(ba);
        wait_done();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lim;
        int wcs[5];
        int m_dat, m_pad, m_keep, m_rep;
        rst = 1'b1; csr_we = 1'b0; dr_we = 1'b0; csr_wdata = '0; dr_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk(csr_q == 16'h0020, "R12", "csr after reset", csr_q, 16'h0020);
        chk(dr_q == 16'd0 && irq == 1'b0 && mem_req == 1'b0, "R12", "dr/irq/req",
            {dr_q, 1'b0, irq, mem_req}, 0);

        // R1 unknown function codes are not started
        wr_csr(16'h0005);
        chk(csr_q[5] == 1'b1 && csr_q[7] == 1'b0, "R1", "func 010 start", csr_q, 16'h0024);
        wr_csr(16'h000F);
        chk(csr_q[5] == 1'b1 && csr_q[7] == 1'b0, "R1", "func 111 start", csr_q, 16'h002E);

        // Sweep of fill / empty / empty over both densities
        for (int d = 0; d < 2; d++) begin
            lim = (d != 0) ? 128 : 64;
            wcs[0] = 0; wcs[1] = 1; wcs[2] = 7; wcs[3] = lim - 1; wcs[4] = lim;
            for (int k = 0; k < 5; k++) begin
                for (int i = 0; i < 128; i++) hmem[i] = 16'(i * 37 + k * 101 + d * 7 + 1);
                for (int i = 128; i < 512; i++) hmem[i] = 16'hDEAD;
                lat = k % 3;
                run(3'b000, d[0], 2'(k), 1'b0, 16'(wcs[k]), 16'h0000);
                chk(csr_q[15] == 1'b0 && dr_q == 16'd0, "R8", "fill status", dr_q, 0);
                chk(ack_cnt == wcs[k], "R3", "fill word reads", ack_cnt, wcs[k]);
                chk(addr_bad == 0, "R10", "fill addresses", addr_bad, 0);
                run(3'b001, d[0], 2'd0, 1'b0, 16'(lim), 16'h0100);
                chk(ack_cnt == lim && addr_bad == 0, "R5", "empty writes", ack_cnt, lim);
                run(3'b001, d[0], 2'd0, 1'b0, 16'(lim), 16'h0200);
                m_dat = 0; m_pad = 0; m_keep = 0; m_rep = 0;
                for (int i = 0; i < lim; i++) begin
                    if (i < wcs[k]) begin
                        if (hmem[128 + i] != hmem[i]) m_dat++;
                    end else if (hmem[128 + i] != 16'd0) m_pad++;
                    if (hmem[256 + i] != hmem[128 + i]) m_rep++;
                end
                if (lim < 128 && hmem[128 + lim] != 16'hDEAD) m_keep++;
                chk(m_dat == 0, "R3", "filled data mismatches", m_dat, 0);
                chk(m_pad == 0, "R4", "pad mismatches", m_pad, 0);
                chk(m_keep == 0, "R5", "empty overran count", m_keep, 0);
                chk(m_rep == 0, "R5", "repeat empty mismatches", m_rep, 0);
            end
        end
        lat = 0;

        // R6 overflow just over each limit and at the maximum count
        run(3'b000, 1'b0, 2'd0, 1'b0, 16'd65, 16'h0000);
        chk(csr_q[15] && csr_q[5] && dr_q == 16'h0400 && ack_cnt == 0, "R6",
            "sd count 65", dr_q, 16'h0400);
        run(3'b001, 1'b1, 2'd0, 1'b0, 16'd129, 16'h0000);
        chk(csr_q[15] && dr_q == 16'h0400 && ack_cnt == 0, "R6", "dd count 129", dr_q, 16'h0400);
        run(3'b000, 1'b1, 2'd0, 1'b0, 16'hFFFF, 16'h0000);
        chk(csr_q[15] && dr_q == 16'h0400 && ack_cnt == 0, "R6", "count ffff", dr_q, 16'h0400);

        // R2 data register write while TR clear has no effect
        wr_dr(16'h1234);
        chk(dr_q == 16'h0400, "R2", "idle data write", dr_q, 16'h0400);

        // R2 TR sequencing between the two parameter writes
        exp_addr = 18'h00000; ack_cnt = 0; addr_bad = 0;
        wr_csr(cmd(3'b000, 1'b0, 2'd0, 1'b0));
        chk(csr_q[7] == 1'b1 && csr_q[5] == 1'b0 && csr_q[15] == 1'b0, "R1", "start flags",
            csr_q, 16'h0080);
        wr_dr(16'd2);
        chk(csr_q[7] == 1'b0, "R2", "TR after count", csr_q[7], 0);
        @(negedge clk);
        chk(csr_q[7] == 1'b1, "R2", "TR re-raised", csr_q[7], 1);
        // R11 control write mid-command: only IE changes
        wr_csr(16'h3143);
        chk(csr_q == 16'h0040 + 16'h0080, "R11", "busy csr write", csr_q, 16'h00C0);
        chk(irq == 1'b0, "R9", "irq while busy", irq, 0);
        wr_dr(16'h0000);
        chk(csr_q[7] == 1'b0, "R2", "TR after address", csr_q[7], 0);
        wait_done();
        chk(ack_cnt == 2 && addr_bad == 0 && csr_q[15] == 1'b0, "R11", "command unaltered",
            ack_cnt, 2);
        chk(irq == 1'b1, "R9", "irq on done with IE", irq, 1);
        wr_csr(16'h0000);
        chk(irq == 1'b0, "R9", "irq with IE clear", irq, 0);

        // R10 carry of the address into the extended bits
        run(3'b000, 1'b0, 2'd1, 1'b0, 16'd4, 16'hFFFC);
        chk(addr_bad == 0 && ack_cnt == 4, "R10", "address carry", addr_bad, 0);

        // R7 acknowledge in the last allowed cycle, then no acknowledge
        lat = 63;
        run(3'b000, 1'b0, 2'd0, 1'b0, 16'd2, 16'h0000);
        chk(csr_q[15] == 1'b0 && dr_q == 16'd0 && ack_cnt == 2, "R7", "ack at 64th cycle",
            dr_q, 0);
        lat = 64;
        run(3'b000, 1'b0, 2'd0, 1'b1, 16'd2, 16'h0000);
        chk(csr_q[15] && csr_q[5] && dr_q == 16'h0800 && ack_cnt == 0, "R7", "timeout abort",
            dr_q, 16'h0800);
        chk(irq == 1'b1, "R9", "irq after abort", irq, 1);
        lat = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule